// File: doc/BRIEF.md
# Receive Header Gating Controller

This block sits between a demodulator's recovered bit stream and the serial receive port of a MAC. It waits for a start-of-frame pulse. It then takes in a 48-bit header made of a signal code, a service byte, a payload length and a check word. It drives a gated serial clock and a data line so that the external controller sees only the header fields and the payload bits. The clock stays quiet while the check word arrives.

At the end of the check word the block validates the header. The CRC must match, and the signal code must equal one of four programmed codes. A valid header lets the payload through and, in late mode, raises the ready flag. An invalid header drops the ready flag and returns the block to its wait state, so no payload bit reaches the port. The receive enable from the controller aborts a frame at any point. The path has no link to any transmit logic, so it can run in full duplex.

Top module: `rxh_gate_ctrl`

## Requirements
- R1: After a start pulse is accepted, each of the next 32 bit strobes produces exactly one active serial clock pulse, one cycle after the strobe, with the strobe's bit on the data line. Header bit i is word bit i of {length[15:0], service[7:0], signal[7:0]}, so the fields arrive LSB first.
- R2: The 16 strobes that follow the header carry the check word. No serial clock pulse is produced for any of them.
- R3: After a valid header, exactly `length` payload bits are clocked out. The block then returns to wait for a start pulse, and further strobes produce no clock pulse.
- R4: A CRC register preset to 0xFFFF is fed the 32 header bits in arrival order. Each step computes fb = reg[15] ^ bit, shifts the register left by one and XORs in 0x1021 when fb is 1. Check bit k (k = 0 arrives first) must equal the inverse of reg[k]. On a mismatch the ready flag is inactive one cycle after the last check bit, and no later strobe is clocked.
- R5: The signal byte must equal one of four codes held in `sig_codes`, with code k at bits [8k+7:8k]. A byte that matches none of them is handled like a CRC failure.
- R6: With `cfg_rdy_late` = 0, the ready flag goes active one cycle after the start pulse. With `cfg_rdy_late` = 1, it stays inactive through the header and check word and goes active one cycle after the last check bit, and only if the header is valid.
- R7: One cycle after `rx_en` goes low, the ready flag is inactive. No strobe is clocked while `rx_en` is low, and a frame in progress is abandoned. After a payload ends, the ready flag stays active until `rx_en` drops.
- R8: `cfg_pol[1]` sets the ready flag polarity and `cfg_pol[0]` sets the serial clock polarity. A value of 1 means active high and 0 means active low, and each output sits at its inactive level while idle and in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | Receive enable from the controller |
| sfd_hit | input | 1 | One-cycle start-of-frame pulse |
| bit_vld | input | 1 | Recovered bit strobe |
| bit_val | input | 1 | Recovered bit value |
| sig_codes | input | 32 | Four accepted signal codes, code k at [8k+7:8k] |
| cfg_rdy_late | input | 1 | 0: ready after start pulse, 1: ready after a valid header |
| cfg_pol | input | 2 | Polarity: bit 1 ready flag, bit 0 serial clock (1 = active high) |
| ser_clk | output | 1 | Gated serial clock |
| ser_dat | output | 1 | Serial data |
| rdy | output | 1 | Data-ready flag |

## Verification
A header with a correct check word and a known code, followed by a patterned payload, shows whether the clock counts and bit order are right for the header fields, the silent check word and the payload limit. The same header with one check bit flipped exposes the CRC path, while a correct check word over an unknown code exposes the code comparison. Each of the four codes is tried on its own. Running under both ready timings and both polarity settings separates the ready timing from the polarity inversion, and dropping enable in the middle of a payload tests the abort.

// File: rtl/rxh_pkg.sv
package rxh_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_CRC,
        ST_PAY
    } rxh_state_e;

    typedef struct packed {
        logic act;
        logic dat;
    } ser_beat_t;

    localparam int          CRC_W_DEF    = 16;
    localparam logic [15:0] CRC_POLY_DEF = 16'h1021;
    localparam logic [15:0] CRC_INIT_DEF = 16'hFFFF;

    function automatic logic drive_lvl(input logic act, input logic act_high);
        return act_high ? act : ~act;
    endfunction

endpackage

// File: rtl/rxh_crc.sv
module rxh_crc #(
    parameter int            W    = rxh_pkg::CRC_W_DEF,
    parameter logic [W-1:0]  POLY = rxh_pkg::CRC_POLY_DEF,
    parameter logic [W-1:0]  INIT = rxh_pkg::CRC_INIT_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] crc
);
    logic         fb;
    logic [W-1:0] nxt;

    always_comb begin
        fb  = crc[W-1] ^ din;
        nxt = {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) crc <= INIT;
        else if (en)    crc <= nxt;
    end
endmodule

// File: rtl/rxh_sig_match.sv
module rxh_sig_match #(
    parameter int SIG_W   = 8,
    parameter int N_CODES = 4
) (
    input  logic [SIG_W-1:0]         sig,
    input  logic [N_CODES*SIG_W-1:0] codes,
    output logic                     hit
);
    logic [N_CODES-1:0] hit_vec;

    for (genvar k = 0; k < N_CODES; k++) begin : g_cmp
        assign hit_vec[k] = (sig == codes[k*SIG_W +: SIG_W]);
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/rxh_ser_out.sv
module rxh_ser_out
    import rxh_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ser_beat_t beat_d,
    input  logic      rdy_act,
    input  logic [1:0] pol,
    output logic      ser_clk,
    output logic      ser_dat,
    output logic      rdy,
    output logic      act_q
);
    ser_beat_t beat_q;

    always_ff @(posedge clk) begin
        if (rst) beat_q <= '0;
        else     beat_q <= beat_d;
    end

    assign act_q   = beat_q.act;
    assign ser_dat = beat_q.dat;
    assign ser_clk = drive_lvl(beat_q.act, pol[0]);
    assign rdy     = drive_lvl(rdy_act, pol[1]);
endmodule

// File: rtl/rxh_gate_ctrl.sv
module rxh_gate_ctrl
    import rxh_pkg::*;
#(
    parameter int SIG_W   = 8,
    parameter int SVC_W   = 8,
    parameter int LEN_W   = 16,
    parameter int CRC_W   = CRC_W_DEF,
    parameter int N_CODES = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rx_en,
    input  logic                     sfd_hit,
    input  logic                     bit_vld,
    input  logic                     bit_val,
    input  logic [N_CODES*SIG_W-1:0] sig_codes,
    input  logic                     cfg_rdy_late,
    input  logic [1:0]               cfg_pol,
    output logic                     ser_clk,
    output logic                     ser_dat,
    output logic                     rdy
);
    localparam int               HDR_W    = SIG_W + SVC_W + LEN_W;
    localparam int               CIDX_W   = $clog2(CRC_W);
    localparam logic [LEN_W-1:0] HDR_LAST = LEN_W'(HDR_W - 1);
    localparam logic [LEN_W-1:0] CRC_LAST = LEN_W'(CRC_W - 1);

    rxh_state_e       state;
    logic [LEN_W-1:0] cnt;
    logic [HDR_W-1:0] hdr_q;
    logic             crc_bad_q;
    logic             rdy_q;
    logic [CRC_W-1:0] crc_q;
    logic [LEN_W-1:0] pay_len;
    logic [SIG_W-1:0] sig_fld;
    logic             sig_ok;
    logic             sfd_take;
    logic             bit_miss;
    logic             crc_end;
    logic             hdr_good;
    logic             hdr_err;
    logic             clk_act_q;
    ser_beat_t        beat_d;

    assign pay_len  = hdr_q[HDR_W-1 -: LEN_W];
    assign sig_fld  = hdr_q[SIG_W-1:0];
    assign sfd_take = (state == ST_IDLE) && rx_en && sfd_hit;
    // check bit k must be the inverse of computed bit k
    assign bit_miss = (bit_val == crc_q[cnt[CIDX_W-1:0]]);
    assign crc_end  = (state == ST_CRC) && rx_en && bit_vld && (cnt == CRC_LAST);
    assign hdr_good = !crc_bad_q && !bit_miss && sig_ok;
    assign hdr_err  = crc_end && !hdr_good;

    rxh_crc #(.W(CRC_W)) u_crc (
        .clk (clk),
        .rst (rst),
        .clr (sfd_take),
        .en  ((state == ST_HDR) && bit_vld),
        .din (bit_val),
        .crc (crc_q)
    );

    rxh_sig_match #(.SIG_W(SIG_W), .N_CODES(N_CODES)) u_match (
        .sig   (sig_fld),
        .codes (sig_codes),
        .hit   (sig_ok)
    );

    always_comb begin
        beat_d.act = bit_vld && rx_en && ((state == ST_HDR) || (state == ST_PAY));
        beat_d.dat = bit_val;
    end

    rxh_ser_out u_out (
        .clk     (clk),
        .rst     (rst),
        .beat_d  (beat_d),
        .rdy_act (rdy_q),
        .pol     (cfg_pol),
        .ser_clk (ser_clk),
        .ser_dat (ser_dat),
        .rdy     (rdy),
        .act_q   (clk_act_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            hdr_q     <= '0;
            crc_bad_q <= 1'b0;
            rdy_q     <= 1'b0;
        end else if (!rx_en) begin
            state <= ST_IDLE;
            cnt   <= '0;
            rdy_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (sfd_hit) begin
                    state     <= ST_HDR;
                    cnt       <= '0;
                    crc_bad_q <= 1'b0;
                    rdy_q     <= !cfg_rdy_late;
                end
                ST_HDR: if (bit_vld) begin
                    hdr_q <= {bit_val, hdr_q[HDR_W-1:1]};
                    if (cnt == HDR_LAST) begin
                        state <= ST_CRC;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_CRC: if (bit_vld) begin
                    crc_bad_q <= crc_bad_q | bit_miss;
                    if (cnt == CRC_LAST) begin
                        cnt <= '0;
                        if (hdr_good) begin
                            rdy_q <= 1'b1;
                            state <= (pay_len == '0) ? ST_IDLE : ST_PAY;
                        end else begin
                            rdy_q <= 1'b0;
                            state <= ST_IDLE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PAY: if (bit_vld) begin
                    if (cnt == pay_len - 1'b1) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_CLK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        clk_act_q |-> $past(bit_vld)); // R1
    AST_CRC_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CRC) |=> !clk_act_q); // R2
    AST_PAY_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PAY) |-> (cnt < pay_len)); // R3
    AST_ERR_ABORT: assert property (@(posedge clk) disable iff (rst)
        hdr_err |=> ((state == ST_IDLE) && !rdy_q)); // R4
    AST_LATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdy_late && ((state == ST_HDR) || (state == ST_CRC))) |-> !rdy_q); // R6
    AST_EN_DROP: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (!rdy_q && !clk_act_q)); // R7
endmodule

// File: tb/tb_rxh_gate_ctrl.sv
module tb_rxh_gate_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        rx_en;
    logic        sfd_hit;
    logic        bit_vld;
    logic        bit_val;
    logic [31:0] sig_codes;
    logic        cfg_rdy_late;
    logic [1:0]  cfg_pol;
    logic        ser_clk;
    logic        ser_dat;
    logic        rdy;

    int           n_chk = 0;
    int           n_err = 0;
    int           pulses = 0;
    logic [255:0] cap;
    bit           finished = 0;

    always #5 clk = ~clk;

    rxh_gate_ctrl dut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .sfd_hit(sfd_hit),
        .bit_vld(bit_vld), .bit_val(bit_val), .sig_codes(sig_codes),
        .cfg_rdy_late(cfg_rdy_late), .cfg_pol(cfg_pol),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .rdy(rdy)
    );

    // count active clock pulses and capture data
    always @(negedge clk) begin
        if (!rst && ser_clk == cfg_pol[0]) begin
            if (pulses < 256) cap[pulses] = ser_dat;
            pulses++;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic rdy_on();
        return rdy == cfg_pol[1];
    endfunction

    function automatic logic [15:0] crc_next(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    endfunction

    task automatic put_bit(input logic b);
        bit_vld = 1'b1;
        bit_val = b;
        @(negedge clk);
        bit_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic gap();
        rx_en = 1'b0;
        @(negedge clk);
        rx_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_header(input logic [7:0] s, input logic [7:0] v, input logic [15:0] l,
                               input bit bad, output logic r_sfd, output logic r_pre,
                               output logic r_post, output int p_hdr, output int p_crc);
        logic [31:0] w;
        logic [15:0] c;
        logic [15:0] f;
        w = {l, v, s};
        c = 16'hFFFF;
        for (int i = 0; i < 32; i++) c = crc_next(c, w[i]);
        f = ~c;
        if (bad) f[0] = ~f[0];
        pulses = 0;
        sfd_hit = 1'b1;
        @(negedge clk);
        sfd_hit = 1'b0;
        r_sfd = rdy_on();
        for (int i = 0; i < 32; i++) put_bit(w[i]);
        p_hdr = pulses;
        for (int i = 0; i < 15; i++) put_bit(f[i]);
        r_pre = rdy_on();
        put_bit(f[15]);
        r_post = rdy_on();
        p_crc = pulses;
    endtask

    task automatic t_reset();
        cfg_pol = 2'b11;
        @(negedge clk);
        check("R8 reset rdy idle level", {31'd0, rdy}, 32'd0);
        check("R8 reset clk idle level", {31'd0, ser_clk}, 32'd0);
    endtask

    task automatic t_good_early();
        logic rs, rp, rq;
        int ph, pc;
        logic [9:0] pat;
        pat = 10'h2D3;
        cfg_pol = 2'b11;
        cfg_rdy_late = 1'b0;
        send_header(8'h14, 8'hA5, 16'd10, 1'b0, rs, rp, rq, ph, pc);
        check("R6 early ready after start", {31'd0, rs}, 32'd1);
        check("R1 header pulse count", ph, 32);
        check("R1 header bits in order", cap[31:0], {16'd10, 8'hA5, 8'h14});
        check("R2 no pulses on check word", pc, 32);
        check("R6 early ready held", {31'd0, rq}, 32'd1);
        for (int i = 0; i < 10; i++) put_bit(pat[i]);
        for (int i = 0; i < 3; i++) put_bit(1'b1);
        check("R3 payload pulse count", pulses, 42);
        check("R3 payload bits", {22'd0, cap[41:32]}, {22'd0, pat});
        check("R7 ready kept after payload", {31'd0, rdy_on()}, 32'd1);
        rx_en = 1'b0;
        @(negedge clk);
        check("R7 ready off after enable low", {31'd0, rdy_on()}, 32'd0);
        rx_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_good_late();
        logic rs, rp, rq;
        int ph, pc;
        cfg_pol = 2'b11;
        cfg_rdy_late = 1'b1;
        send_header(8'h0A, 8'h3C, 16'd4, 1'b0, rs, rp, rq, ph, pc);
        check("R6 late not ready after start", {31'd0, rs}, 32'd0);
        check("R6 late not ready in check word", {31'd0, rp}, 32'd0);
        check("R6 late ready after header", {31'd0, rq}, 32'd1);
        for (int i = 0; i < 6; i++) put_bit(i[0]);
        check("R3 short payload pulse count", pulses, 36);
        gap();
    endtask

    task automatic t_crc_err(input logic late);
        logic rs, rp, rq;
        int ph, pc;
        cfg_pol = 2'b11;
        cfg_rdy_late = late;
        send_header(8'h37, 8'h00, 16'd8, 1'b1, rs, rp, rq, ph, pc);
        if (!late) check("R6 early ready before bad check word", {31'd0, rs}, 32'd1);
        check("R4 ready inactive after bad CRC", {31'd0, rq}, 32'd0);
        for (int i = 0; i < 5; i++) put_bit(1'b1);
        check("R4 no payload after bad CRC", pulses, 32);
        gap();
    endtask

    task automatic t_sig_miss();
        logic rs, rp, rq;
        int ph, pc;
        cfg_pol = 2'b11;
        cfg_rdy_late = 1'b1;
        send_header(8'h55, 8'h11, 16'd6, 1'b0, rs, rp, rq, ph, pc);
        check("R5 unknown code no ready", {31'd0, rq}, 32'd0);
        for (int i = 0; i < 6; i++) put_bit(1'b0);
        check("R5 unknown code no payload", pulses, 32);
        gap();
    endtask

    task automatic t_all_codes();
        logic rs, rp, rq;
        int ph, pc;
        cfg_pol = 2'b11;
        cfg_rdy_late = 1'b1;
        for (int k = 0; k < 4; k++) begin
            send_header(sig_codes[k*8 +: 8], 8'h5A, 16'd2, 1'b0, rs, rp, rq, ph, pc);
            check("R5 each programmed code accepted", {31'd0, rq}, 32'd1);
            put_bit(1'b1);
            put_bit(1'b0);
            check("R5 payload after code", pulses, 34);
            gap();
        end
    endtask

    task automatic t_polarity();
        logic rs, rp, rq;
        int ph, pc;
        cfg_pol = 2'b00;
        cfg_rdy_late = 1'b0;
        @(negedge clk);
        check("R8 low-active idle clk level", {31'd0, ser_clk}, 32'd1);
        check("R8 low-active idle rdy level", {31'd0, rdy}, 32'd1);
        send_header(8'h6E, 8'h01, 16'd3, 1'b0, rs, rp, rq, ph, pc);
        check("R8 low-active ready drives 0", {31'd0, rdy}, 32'd0);
        check("R8 low-active header pulses", ph, 32);
        check("R8 low-active header bits", cap[31:0], {16'd3, 8'h01, 8'h6E});
        gap();
        cfg_pol = 2'b01;
        @(negedge clk);
        check("R8 mixed idle rdy level", {31'd0, rdy}, 32'd1);
        check("R8 mixed idle clk level", {31'd0, ser_clk}, 32'd0);
    endtask

    task automatic t_abort();
        logic rs, rp, rq;
        int ph, pc;
        cfg_pol = 2'b11;
        cfg_rdy_late = 1'b0;
        send_header(8'h14, 8'h77, 16'd20, 1'b0, rs, rp, rq, ph, pc);
        for (int i = 0; i < 5; i++) put_bit(1'b1);
        rx_en = 1'b0;
        for (int i = 0; i < 3; i++) put_bit(1'b1);
        check("R7 no pulses with enable low", pulses, 37);
        check("R7 ready off on abort", {31'd0, rdy_on()}, 32'd0);
        rx_en = 1'b1;
        for (int i = 0; i < 3; i++) put_bit(1'b1);
        check("R7 abandoned frame stays closed", pulses, 37);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        rx_en = 1'b0;
        sfd_hit = 1'b0;
        bit_vld = 1'b0;
        bit_val = 1'b0;
        cfg_rdy_late = 1'b0;
        cfg_pol = 2'b11;
        sig_codes = {8'h6E, 8'h37, 8'h14, 8'h0A};
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        rx_en = 1'b1;
        @(negedge clk);
        t_good_early();
        t_good_late();
        t_crc_err(1'b1);
        t_crc_err(1'b0);
        t_sig_miss();
        t_all_codes();
        t_polarity();
        t_abort();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule